// File: doc/BRIEF.md
# Power-Fail Recall and Store-Inhibit Sequencer

This block supervises the supply of a shadow-memory device, where every volatile cell has a nonvolatile copy. It has three digitised comparator flags: one says the supply is above the reset level, one says it is above the store-inhibit level, and one says it is above the switch level. Each flag is synchronised to the local clock. The flags are treated as nested, so a flag for a higher level counts as low whenever a lower-level flag is low.

The block drives three outputs. The store-block output is high whenever the supply is too low to program the nonvolatile copy. A one-cycle recall-start pulse tells the memory to reload its volatile array from the nonvolatile copy. The ready output holds off normal memory access until that reload has had its full duration.

A recall request is pending from reset. A new request is recorded every time the supply falls below the reset level. The request is consumed when the supply next rises above the switch level. A shallow brownout that never reaches the reset level blocks stores but leaves the request state unchanged, so no recall follows it.

Top module: `pwr_recall_seq`

## Requirements
- R1: While reset is asserted and just after it is released with all flags low, store_block_o is 1, recall_start_o is 0 and ready_o is 0.
- R2: Each comparator flag passes through a two-flop synchroniser. A flag change applied between clock edges is first seen in the outputs after the second rising edge that follows it.
- R3: store_block_o is 1 whenever the synchronised inhibit flag or the synchronised reset flag is 0, and 0 otherwise.
- R4: A recall request is pending after reset. A new request is latched on every cycle in which the synchronised reset flag is 0.
- R5: recall_start_o is a single-cycle pulse. It is raised when a request is pending and the nested switch flag is 1, and it clears the pending request.
- R6: A brownout that drops the inhibit and switch flags while the reset flag stays 1 produces no recall_start_o, and ready_o stays 1 throughout.
- R7: ready_o rises exactly RECALL_CYCLES clock edges after the edge that ends the recall_start_o pulse.
- R8: ready_o is 0 while a recall is running. One cycle after the synchronised reset flag goes to 0, ready_o is 0 and any running recall is abandoned.
- R9: If the supply falls below the reset level during a recall, the new request is kept. A fresh recall, with the full duration, starts when the switch level is reached again.
- R10: A switch or inhibit flag that reads 1 while the reset flag reads 0 is treated as 0. In that state the block gives no recall start, and stores stay blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lvl_reset_i | input | 1 | Asynchronous flag: supply above reset level |
| lvl_inhibit_i | input | 1 | Asynchronous flag: supply above store-inhibit level |
| lvl_switch_i | input | 1 | Asynchronous flag: supply above switch level |
| store_block_o | output | 1 | Nonvolatile store must not be started |
| recall_start_o | output | 1 | One-cycle pulse that starts a recall |
| ready_o | output | 1 | Recall complete, normal access allowed |

## Verification
The hardest case to reach is a supply collapse in the middle of a running recall. The stimulus first raises all three flags. It then waits a few cycles past the start pulse, so the duration counter is partway through, and drops all flags to zero. It holds them low for longer than a full recall duration, which proves that the abandoned recall never raises ready on its own. When the flags are raised again, the bench expects a new start pulse two edges later and ready exactly one full duration after that.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef struct packed {
    logic sw;
    logic inh;
    logic rst;
  } supply_lvl_t;

  // Enforce nesting: a higher threshold cannot be above while a lower is not.
  function automatic supply_lvl_t nest_levels(supply_lvl_t raw);
    supply_lvl_t n;
    n.rst = raw.rst;
    n.inh = raw.inh & raw.rst;
    n.sw  = raw.sw & n.inh;
    return n;
  endfunction

  // True on the last cycle of a window of 'limit' cycles counted from zero.
  function automatic logic window_done(logic [31:0] cnt, logic [31:0] limit);
    return cnt == (limit - 32'd1);
  endfunction

endpackage

// File: rtl/pwr_flag_sync.sv
module pwr_flag_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/pwr_req_latch.sv
module pwr_req_latch
  import pwr_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  supply_lvl_t lvl_i,
  output logic        req_o,
  output logic        start_o
);

  logic req_q;

  assign start_o = req_q & lvl_i.sw;
  assign req_o   = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         req_q <= 1'b1;
    else if (!lvl_i.rst) req_q <= 1'b1;
    else if (start_o)    req_q <= 1'b0;
  end

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R5
  AST_REQ_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_i.rst |=> req_o); // R4
  AST_NO_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_i.rst |-> !start_o); // R10

endmodule

// File: rtl/pwr_recall_timer.sv
module pwr_recall_timer
  import pwr_seq_pkg::*;
#(
  parameter int RECALL_CYCLES = 55000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic expire_o,
  output logic ready_o
);

  localparam int CNT_W = $clog2(RECALL_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             ready_q;

  assign expire_o = busy_q & window_done(32'(cnt_q), 32'(RECALL_CYCLES));
  assign busy_o   = busy_q;
  assign ready_o  = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (expire_o) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_READY_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o); // R8
  AST_READY_AFTER_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(expire_o)); // R7
  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !ready_o && !busy_o); // R8

endmodule

// File: rtl/pwr_recall_seq.sv
module pwr_recall_seq
  import pwr_seq_pkg::*;
#(
  parameter int RECALL_CYCLES = 55000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_reset_i,
  input  logic lvl_inhibit_i,
  input  logic lvl_switch_i,
  output logic store_block_o,
  output logic recall_start_o,
  output logic ready_o
);

  supply_lvl_t raw_lvl;
  supply_lvl_t sync_lvl;
  supply_lvl_t lvl;
  logic        req_pending;
  logic        recall_start;
  logic        recall_busy;
  logic        recall_expire;

  assign raw_lvl = '{sw: lvl_switch_i, inh: lvl_inhibit_i, rst: lvl_reset_i};

  pwr_flag_sync #(
    .WIDTH  ($bits(supply_lvl_t)),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (raw_lvl),
    .sync_o  (sync_lvl)
  );

  assign lvl = nest_levels(sync_lvl);

  pwr_req_latch req_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl),
    .req_o   (req_pending),
    .start_o (recall_start)
  );

  pwr_recall_timer #(
    .RECALL_CYCLES (RECALL_CYCLES)
  ) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (recall_start),
    .abort_i  (!lvl.rst),
    .busy_o   (recall_busy),
    .expire_o (recall_expire),
    .ready_o  (ready_o)
  );

  assign store_block_o  = !lvl.inh;
  assign recall_start_o = recall_start;

  AST_BLOCK_BELOW_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_lvl.rst |-> store_block_o); // R3
  AST_START_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_start_o |=> !req_pending || !lvl.rst); // R5
  AST_EXPIRE_IN_RECALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_expire |-> recall_busy && !ready_o); // R7

endmodule

// File: tb/pwr_recall_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_recall_seq_tb_top;

  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_rst = 1'b0, f_inh = 1'b0, f_sw = 1'b0;
  logic store_block, recall_start, ready;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwr_recall_seq #(.RECALL_CYCLES(N)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .lvl_reset_i    (f_rst),
    .lvl_inhibit_i  (f_inh),
    .lvl_switch_i   (f_sw),
    .store_block_o  (store_block),
    .recall_start_o (recall_start),
    .ready_o        (ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_lvl(input logic r, input logic h, input logic s);
    f_rst = r; f_inh = h; f_sw = s;
  endtask

  // Raise all flags from a low state; expects a recall and checks its timing.
  task automatic rise_and_recall(input string req);
    set_lvl(1, 1, 1);
    step(1);
    chk("R2", {req, " start before 2nd edge"}, recall_start, 0);
    chk("R2", {req, " block before 2nd edge"}, store_block, 1);
    step(1);
    chk("R5", {req, " start pulse"}, recall_start, 1);
    chk("R3", {req, " block released"}, store_block, 0);
    step(1);
    chk("R5", {req, " start single cycle"}, recall_start, 0);
    chk("R8", {req, " ready low in recall"}, ready, 0);
    step(N - 1);
    chk("R7", {req, " ready one cycle early"}, ready, 0);
    step(1);
    chk("R7", {req, " ready at duration"}, ready, 1);
  endtask

  task automatic t_reset;
    step(2);
    chk("R1", "block in reset", store_block, 1);
    chk("R1", "start in reset", recall_start, 0);
    chk("R1", "ready in reset", ready, 0);
    rst_n = 1'b1;
    step(3);
    chk("R1", "block after reset", store_block, 1);
    chk("R1", "start after reset", recall_start, 0);
    chk("R1", "ready after reset", ready, 0);
  endtask

  task automatic t_powerup;
    rise_and_recall("R4 power-up");
  endtask

  task automatic t_brownout;
    int starts = 0;
    int ready_drop = 0;
    set_lvl(1, 0, 0);
    step(2);
    chk("R3", "block in brownout", store_block, 1);
    chk("R6", "ready in brownout", ready, 1);
    set_lvl(1, 1, 1);
    for (int i = 0; i < N + 4; i++) begin
      step(1);
      if (recall_start) starts++;
      if (!ready) ready_drop++;
    end
    chk("R6", "no recall after brownout", starts, 0);
    chk("R6", "ready held over brownout", ready_drop, 0);
    chk("R3", "block cleared after brownout", store_block, 0);
  endtask

  task automatic t_deep_dip;
    set_lvl(0, 0, 0);
    step(2);
    chk("R3", "block below reset", store_block, 1);
    step(1);
    chk("R8", "ready dropped below reset", ready, 0);
    step(4);
    rise_and_recall("R4 deep dip");
  endtask

  task automatic t_dip_in_recall;
    int early = 0;
    set_lvl(0, 0, 0);
    step(6);
    set_lvl(1, 1, 1);
    step(2);
    chk("R9", "first start", recall_start, 1);
    step(5);
    set_lvl(0, 0, 0);
    for (int i = 0; i < N + 6; i++) begin
      step(1);
      if (ready || recall_start) early++;
    end
    chk("R8", "aborted recall stays not ready", early, 0);
    rise_and_recall("R9 restart");
  endtask

  task automatic t_nesting;
    int starts = 0;
    int unblock = 0;
    set_lvl(0, 0, 0);
    step(4);
    set_lvl(0, 1, 1);
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (recall_start) starts++;
      if (!store_block) unblock++;
    end
    chk("R10", "no start with reset flag low", starts, 0);
    chk("R10", "stores blocked with reset flag low", unblock, 0);
    chk("R10", "not ready", ready, 0);
    rise_and_recall("R10 after nesting");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_powerup();
    t_brownout();
    t_deep_dip();
    t_dip_in_recall();
    t_nesting();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule